// File: doc/BRIEF.md
# Free-Running Counter Compare Unit

The unit keeps a 32-bit up counter that advances once per clock while the tick input is high and wraps from all-ones to zero. Beside it sit eight 32-bit compare slots. Each slot can be enabled on its own. When the counter steps into a value equal to an enabled slot, the unit latches a sticky per-slot status bit and raises a compare interrupt. This line is separate from the counter's own wrap pulse.

A match never stops, reloads or resets the counter, so the same counter can act as a timebase and as a source of one-shot events. Software reads the count, adds a delta using wrapping 32-bit addition, and writes the sum into a slot. The event then fires exactly delta ticks later, even when the sum has wrapped past zero.

Top module: `frc_cmp_unit`

## Requirements
- R1: After reset the count, all compare slots, the enable mask (offset 0x80) and the status register (offset 0x84) read 0, and both cmp_irq_o and ovf_o are low.
- R2: On every clock with tick_i high and no count write, the counter (read at offset 0x10) increases by 1 and wraps from 0xFFFFFFFF to 0. With tick_i low it holds. A compare match never alters it.
- R3: A write to offset 0x10 loads the counter on that clock. The load takes priority over the increment.
- R4: Compare slot k is read and written at offset 0x60 + 4*k, for k = 0..7. A newly written value is used for matching from the following clock on. On the clock of the write itself, the old value is used.
- R5: Status bit k sets on the clock where the counter advances by a tick into the value of slot k while enable bit k is set. A counter load that lands on the value does not set it.
- R6: A slot holding a value reached only after a wrap (for example 0 when the count is near 0xFFFFFFFF) matches when the wrapped counter arrives there.
- R7: A slot holding a value the counter has already passed gives no event until the counter comes round to it again.
- R8: Writing 1 to bit k at offset 0x84 clears status bit k, and writing 0 leaves it unchanged. If a match and a clear of the same bit fall on the same clock, the bit stays set.
- R9: cmp_irq_o is high exactly while at least one status bit is set.
- R10: ovf_o is high for exactly one clock, the clock after the counter wraps from 0xFFFFFFFF to 0.
- R11: A slot whose enable bit is 0 never sets its status bit. Reads from unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter advance enable |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| cmp_irq_o | output | 1 | Compare interrupt, OR of status bits |
| ovf_o | output | 1 | One-clock pulse after counter wrap |

## Verification
The hardest situations to reach are the ones that depend on the exact clock of a match. These are a match that lands on the wrap to zero, a clear that collides with a match, and a compare write on the very clock the counter reaches the new value. A natural run would need about 2^32 ticks to reach the wrap. The stimulus avoids this by loading the counter a few counts below it while the tick is off, and then releasing the tick for a counted number of clocks. The collision cases are set up the same way, with the register write placed on the computed clock of equality.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int unsigned OFS_COUNT  = 32'h10;
  localparam int unsigned OFS_CMP0   = 32'h60;
  localparam int unsigned CMP_STRIDE = 4;
  localparam int unsigned OFS_ENA    = 32'h80;
  localparam int unsigned OFS_STS    = 32'h84;
endpackage

// File: rtl/frc_counter.sv
module frc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             step_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q;

  assign step_o = tick_i & ~load_i;

  always_comb begin
    if (load_i)      cnt_nxt_o = load_val_i;
    else if (tick_i) cnt_nxt_o = cnt_q + CNT_W'(1);
    else             cnt_nxt_o = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt_o;
      wrap_q <= step_o & (&cnt_q);
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> cnt_o == $past(cnt_o) + CNT_W'(1));
  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_o));
  // R10
  ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> cnt_o == '0);
endmodule

// File: rtl/frc_cmp_slot.sv
module frc_cmp_slot #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             en_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmp_q <= '0;
    else if (wr_i) cmp_q <= wdata_i;
  end

  // equality on the step into the value, against the value held before any write this clock
  assign hit_o = en_i & step_i & (cnt_nxt_i == cmp_q);
  assign cmp_o = cmp_q;

  // R4
  cmp_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cmp_o == $past(wdata_i));
endmodule

// File: rtl/frc_status.sv
module frc_status #(
  parameter int unsigned N_CMP = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CMP-1:0] hit_i,
  input  logic [N_CMP-1:0] clr_i,
  output logic [N_CMP-1:0] sts_o
);
  logic [N_CMP-1:0] sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (sts_q & ~clr_i) | hit_i;
  end

  assign sts_o = sts_q;

  // R5
  sts_set_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sts_o & ~$past(sts_o) & ~$past(hit_i)) == '0);
  // R8
  sts_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sts_o & $past(clr_i) & ~$past(hit_i)) == '0);
  // R8
  sts_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sts_o & $past(hit_i)) == $past(hit_i));
endmodule

// File: rtl/frc_cmp_unit.sv
module frc_cmp_unit #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned N_CMP  = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              cmp_irq_o,
  output logic              ovf_o
);
  import frc_pkg::*;

  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_ENA   = ADDR_W'(OFS_ENA);
  localparam logic [ADDR_W-1:0] A_STS   = ADDR_W'(OFS_STS);

  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             step;
  logic [N_CMP-1:0] ena_q, hit, clr, sts;
  logic [CNT_W-1:0] cmp_val [N_CMP];

  frc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (wr_i && addr_i == A_COUNT),
    .load_val_i (wdata_i),
    .cnt_o      (cnt),
    .cnt_nxt_o  (cnt_nxt),
    .step_o     (step),
    .wrap_o     (ovf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ena_q <= '0;
    else if (wr_i && addr_i == A_ENA) ena_q <= wdata_i[N_CMP-1:0];
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_slot
    localparam logic [ADDR_W-1:0] A_SLOT = ADDR_W'(OFS_CMP0 + CMP_STRIDE * k);
    frc_cmp_slot #(.CNT_W(CNT_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_i && addr_i == A_SLOT),
      .wdata_i   (wdata_i),
      .en_i      (ena_q[k]),
      .step_i    (step),
      .cnt_nxt_i (cnt_nxt),
      .cmp_o     (cmp_val[k]),
      .hit_o     (hit[k])
    );
  end

  assign clr = (wr_i && addr_i == A_STS) ? wdata_i[N_CMP-1:0] : '0;

  frc_status #(.N_CMP(N_CMP)) u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .clr_i  (clr),
    .sts_o  (sts)
  );

  assign cmp_irq_o = |sts;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_COUNT) rdata_o = cnt;
    if (addr_i == A_ENA)   rdata_o[N_CMP-1:0] = ena_q;
    if (addr_i == A_STS)   rdata_o[N_CMP-1:0] = sts;
    for (int k = 0; k < N_CMP; k++)
      if (addr_i == ADDR_W'(OFS_CMP0 + CMP_STRIDE * k)) rdata_o = cmp_val[k];
  end

  // R11
  dis_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sts & ~$past(sts) & ~$past(ena_q)) == '0);
  // R9
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmp_irq_o) |-> $past(hit) != '0);
endmodule

// File: tb/sim_frc_cmp_unit.sv
`timescale 1ns/1ps
module sim_frc_cmp_unit;
  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, ovf;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  localparam logic [7:0] A_CNT = 8'h10, A_CMP = 8'h60, A_ENA = 8'h80, A_STS = 8'h84;

  // {slot, base, delta}
  localparam logic [67:0] VEC [5] = '{
    {4'd0, 32'h0000_0000, 32'd5},
    {4'd3, 32'd100,       32'd1},
    {4'd7, 32'hFFFF_FFFE, 32'd2},
    {4'd5, 32'hFFFF_FFF0, 32'd20},
    {4'd1, 32'd1000,      32'd3}
  };

  always #4 clk = ~clk;

  frc_cmp_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cmp_irq_o(irq), .ovf_o(ovf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic run(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(A_CNT, d); check("R1 count", d, 0);
    bus_rd(A_CMP + 8'd28, d); check("R1 cmp7", d, 0);
    bus_rd(A_ENA, d); check("R1 ena", d, 0);
    bus_rd(A_STS, d); check("R1 sts", d, 0);
    check("R1 irq/ovf", {irq, ovf}, 0);

    // vector walk: R5 R6 R2 R8 R9
    for (int i = 0; i < 5; i++) begin
      logic [3:0]  s;
      logic [31:0] b, dl;
      s = VEC[i][67:64]; b = VEC[i][63:32]; dl = VEC[i][31:0];
      bus_wr(A_CNT, b);
      bus_wr(A_ENA, 32'd1 << s);
      bus_wr(A_CMP + 8'(4 * s), b + dl);
      bus_wr(A_STS, 32'hFF);
      if (dl > 1) run(int'(dl) - 1);
      bus_rd(A_STS, d); check("R5 before match", d, 0);
      run(1);
      bus_rd(A_STS, d); check("R5 R6 at match", d, 32'd1 << s);
      check("R9 irq set", irq, 1);
      bus_rd(A_CNT, d); check("R2 count after ticks", d, b + dl);
      bus_wr(A_STS, 32'd1 << s);
      bus_rd(A_STS, d); check("R8 w1c clear", d, 0);
      check("R9 irq clear", irq, 0);
    end

    // R2 hold with tick low
    bus_rd(A_CNT, d);
    repeat (4) @(negedge clk);
    begin logic [31:0] d2; bus_rd(A_CNT, d2); check("R2 hold", d2, d); end

    // R3 load wins over tick, R5 load onto value gives no event
    bus_wr(A_CMP + 8'd16, 32'd150);
    bus_wr(A_ENA, 32'h10);
    tick = 1'b1;
    bus_wr(A_CNT, 32'd150);
    tick = 1'b0;
    bus_rd(A_CNT, d); check("R3 load priority", d, 150);
    bus_rd(A_STS, d); check("R5 load no event", d, 0);

    // R7 passed value: no event
    run(20);
    bus_rd(A_CNT, d); check("R7 count", d, 170);
    bus_rd(A_STS, d); check("R7 no event", d, 0);

    // R8 set wins over clear same clock
    bus_wr(A_CNT, 32'd50);
    bus_wr(A_CMP + 8'd8, 32'd52);
    bus_wr(A_ENA, 32'h04);
    tick = 1'b1;
    @(negedge clk);
    bus_wr(A_STS, 32'h04);
    tick = 1'b0;
    bus_rd(A_STS, d); check("R8 set wins", d, 32'h04);
    bus_wr(A_STS, 32'hFF);

    // R4 write on clock of equality uses old value
    bus_wr(A_ENA, 32'h01);
    bus_wr(A_CNT, 32'd300);
    tick = 1'b1;
    bus_wr(A_CMP, 32'd301);
    tick = 1'b0;
    bus_rd(A_STS, d); check("R4 old value used", d, 0);
    bus_rd(A_CMP, d); check("R4 readback", d, 301);

    // R11 disabled slot
    bus_wr(A_ENA, 32'h00);
    bus_wr(A_CMP + 8'd24, 32'd304);
    run(6);
    bus_rd(A_STS, d); check("R11 disabled", d, 0);
    check("R11 irq low", irq, 0);
    bus_rd(8'h40, d); check("R11 unmapped read", d, 0);
    bus_wr(8'h44, 32'hDEAD_BEEF);
    bus_rd(A_CMP + 8'd24, d); check("R11 unmapped write", d, 304);

    // R10 wrap pulse
    bus_wr(A_CNT, 32'hFFFF_FFFF);
    check("R10 no pulse on load", ovf, 0);
    run(1);
    check("R10 pulse", ovf, 1);
    bus_rd(A_CNT, d); check("R10 wrapped", d, 0);
    run(1);
    check("R10 one clock", ovf, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule